// File: doc/BRIEF.md
# Serial Peripheral Link Controller with Master-Loss Detection

This block is a byte-wide serial peripheral port that software sets up through a small register interface. Each node holds one shift register. The master's data-out line feeds the slave's data-in line, and the slave's data-out line returns to the master, so the two shift registers form a closed ring. After eight clock periods the two nodes have swapped their bytes. Bits leave most-significant first. The master makes the serial clock by dividing the system clock. A slave brings the incoming clock and select lines through synchronizers and acts on their edges.

Outgoing data has only one buffer: a byte written during a shift is refused. Incoming data has two: each finished byte is copied to a read holder, which stays readable while the next byte shifts in. The block also outputs the pin directions it wants for the four serial lines. When it is master and its select line is an input, a low level on that line means another master has claimed the bus. The block then drops to slave, stops driving the clock and data-out lines, and raises its completion flag.

Top module: `spi_link_ctrl`

## Requirements
- R1: After reset, reads of control (select 0), status (select 1) and data (select 2) all return 0x00, and the interrupt output is low. Control fields are bit 0 enable, bit 1 master, bit 2 interrupt enable and bits 4:3 divider select. Status bit 0 is completion and bit 1 is collision.
- R2: A master and a slave linked in a ring swap bytes. Each node's data register then reads back the other node's written byte. The master's data-out line carries bit 7 before the first clock edge.
- R3: A data write while a transfer is in progress sets collision (status bit 1) and does not change the byte being shifted out.
- R4: A received byte stays readable while the next byte shifts in. If it has not been read, the next finished byte replaces it.
- R5: Completion (status bit 0) is clear mid-transfer and set after the eighth bit. A status read that sees a flag, followed by a data-register access, clears both flags.
- R6: The master serial clock stays high for 2, 8, 32 or 64 system clocks per bit, for divider select 0, 1, 2 or 3 (divide by 4, 16, 64 or 128).
- R7: When disabled, every pin direction follows the user direction inputs. An enabled master forces data-in (miso) to input, and the other three lines follow the user directions.
- R8: An enabled slave forces data-out (mosi), clock and select to inputs. Its miso drives only while select is low and the user direction is output.
- R9: A master whose select line is set as an output ignores the level on that line.
- R10: A master whose select line is an input and is seen low clears its master bit, sets completion, and releases the mosi and clock lines.
- R11: The interrupt output is high only when completion, interrupt enable and the global enable input are all set.
- R12: After a mode fault the master bit stays 0 until software writes it to 1.
- R13: A slave with select high ignores clock activity. Its completion flag and data register do not change, and it does not drive miso.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag-clear sequence) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| glob_irq_en | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| usr_mosi_dir | input | 1 | User direction for mosi (1 = output) |
| usr_miso_dir | input | 1 | User direction for miso (1 = output) |
| usr_sck_dir | input | 1 | User direction for the clock line (1 = output) |
| usr_ss_dir | input | 1 | User direction for select (1 = output) |
| mosi_i | input | 1 | mosi line level, used as slave data input |
| mosi_o | output | 1 | Master serial data out |
| mosi_oe | output | 1 | Effective mosi direction |
| miso_i | input | 1 | miso line level, used as master data input |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Effective miso direction |
| sck_i | input | 1 | Serial clock line level (slave) |
| sck_o | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | Effective clock direction |
| ss_i | input | 1 | Select line level |
| ss_oe | output | 1 | Effective select direction |

## Verification
The bench builds two copies with the default parameters: an 8-bit data width and two synchronizer stages. One copy is master and the other is slave, joined in a real ring, so every exchanged byte proves both shift directions and the MSB-first order against the other node rather than a model. The ring transfers use divider select 1, which leaves the slave's synchronizer delay well inside each half period. The other three divider settings are measured by counting system clocks while the master clock is high. Because the data width is eight, the overwrite, collision and mode-fault cases each finish within a few hundred cycles.

// File: rtl/spi_link_pkg.sv
// Shared constants for the serial link controller: register select codes,
// control/status bit positions and the divider ratio lookup.
package spi_link_pkg;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int CTL_EN     = 0;
    localparam int CTL_MSTR   = 1;
    localparam int CTL_IE     = 2;
    localparam int CTL_DIV_LO = 3;

    localparam int ST_DONE = 0;
    localparam int ST_COL  = 1;

    localparam int MAX_DIV = 128;

    // System clocks per serial clock period for each divider select code.
    function automatic int div_ratio(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 16;
            2'd2:    return 64;
            default: return 128;
        endcase
    endfunction

endpackage

// File: rtl/spi_link_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes inputs change slowly relative to clk; each bit is synchronized alone.
module spi_link_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Stage g: capture the previous stage (or the pin for stage 0).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain[g] <= d_i;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/spi_link_clkdiv.sv
// Serial clock generator for master mode.
// While run_i is high the clock toggles every ratio/2 system clocks; it idles
// low otherwise. rise_o / fall_o mark the cycle whose edge makes that toggle.
module spi_link_clkdiv
    import spi_link_pkg::*;
#(
    parameter int MAX_RATIO = MAX_DIV
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] div_sel_i,
    output logic       sck_o,
    output logic       rise_o,
    output logic       fall_o
);

    localparam int MAX_HALF = MAX_RATIO / 2;
    localparam int CW       = $clog2(MAX_HALF);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_m1;
    logic          wrap;

    // Last count value of one half period for the chosen ratio.
    assign half_m1 = CW'(div_ratio(div_sel_i) / 2 - 1);
    assign wrap    = run_i && (cnt_q == half_m1);

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            sck_o <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sck_o <= ~sck_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rise_o = wrap && !sck_o;
    assign fall_o = wrap && sck_o;

endmodule

// File: rtl/spi_link_shifter.sv
// Single shift register shared by both roles, MSB first.
// Samples the incoming bit on sample_en and shifts it in on shift_en; the
// byte is complete on the W-th shift. load has priority over abort.
module spi_link_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         sample_en_i,
    input  logic         sample_bit_i,
    input  logic         shift_en_i,
    input  logic         abort_i,
    output logic         tx_bit_o,
    output logic [W-1:0] rx_byte_o,
    output logic         byte_done_o,
    output logic         in_frame_o
);

    localparam int              CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(W - 1);

    logic [W-1:0]     sh_q;
    logic             smp_q;
    logic             half_q;
    logic [CNT_W-1:0] bcnt_q;

    // Shift register, sampled bit and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            smp_q  <= 1'b0;
            half_q <= 1'b0;
            bcnt_q <= '0;
        end else if (load_i) begin
            sh_q   <= load_data_i;
            half_q <= 1'b0;
            bcnt_q <= '0;
        end else if (abort_i) begin
            half_q <= 1'b0;
            bcnt_q <= '0;
        end else begin
            if (sample_en_i) begin
                smp_q  <= sample_bit_i;
                half_q <= 1'b1;
            end
            if (shift_en_i) begin
                sh_q   <= {sh_q[W-2:0], smp_q};
                half_q <= 1'b0;
                bcnt_q <= (bcnt_q == LAST) ? '0 : bcnt_q + 1'b1;
            end
        end
    end

    assign tx_bit_o    = sh_q[W-1];
    assign rx_byte_o   = {sh_q[W-2:0], smp_q};
    assign byte_done_o = shift_en_i && !load_i && !abort_i && (bcnt_q == LAST);
    assign in_frame_o  = half_q || (bcnt_q != '0);

endmodule

// File: rtl/spi_link_ctrl.sv
// Serial link controller top: registers, role control, mode-fault detection,
// receive holding buffer and pin direction overrides.
// Assumes in slave mode the incoming clock is at least 4x slower than clk.
module spi_link_ctrl
    import spi_link_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              glob_irq_en,
    output logic              irq_o,
    input  logic              usr_mosi_dir,
    input  logic              usr_miso_dir,
    input  logic              usr_sck_dir,
    input  logic              usr_ss_dir,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              ss_i,
    output logic              ss_oe
);

    localparam int CTL_USED = CTL_DIV_LO + 2;

    logic              en_q, mstr_q, ie_q;
    logic [1:0]        div_q;
    logic              done_q, col_q, armed_q;
    logic              m_busy_q;
    logic [DATA_W-1:0] rx_buf_q;
    logic              sck_s, ss_s, sck_d;

    logic wr_ctrl, wr_data, rd_data, rd_stat;
    logic is_master, is_slave, ss_active, fault;
    logic sl_rise, sl_fall;
    logic div_rise, div_fall, div_sck;
    logic sh_load, sh_abort, sh_done, sh_tx, in_frame;
    logic [DATA_W-1:0] sh_rx;
    logic busy_any, done_evt, flag_clr;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:CTL_USED];

    // Register strobes.
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_data = reg_wr && (reg_sel == SEL_DATA);
    assign rd_data = reg_rd && (reg_sel == SEL_DATA);
    assign rd_stat = reg_rd && (reg_sel == SEL_STAT);

    spi_link_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({ss_i, sck_i}),
        .q_o  ({ss_s, sck_s})
    );

    // Previous synchronized clock level for slave edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign is_master = en_q && mstr_q;
    assign is_slave  = en_q && !mstr_q;
    assign ss_active = is_slave && !ss_s;
    assign fault     = is_master && !usr_ss_dir && !ss_s;
    assign sl_rise   = ss_active && sck_s && !sck_d;
    assign sl_fall   = ss_active && !sck_s && sck_d;

    spi_link_clkdiv #(
        .MAX_RATIO(MAX_DIV)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (m_busy_q),
        .div_sel_i(div_q),
        .sck_o    (div_sck),
        .rise_o   (div_rise),
        .fall_o   (div_fall)
    );

    assign busy_any = is_master ? m_busy_q : (ss_active && in_frame);
    assign sh_load  = wr_data && !busy_any;
    assign sh_abort = fault || !en_q || (is_slave && ss_s);

    spi_link_shifter #(
        .W(DATA_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sh_load),
        .load_data_i (reg_wdata),
        .sample_en_i (is_master ? div_rise : sl_rise),
        .sample_bit_i(is_master ? miso_i : mosi_i),
        .shift_en_i  (is_master ? div_fall : sl_fall),
        .abort_i     (sh_abort),
        .tx_bit_o    (sh_tx),
        .rx_byte_o   (sh_rx),
        .byte_done_o (sh_done),
        .in_frame_o  (in_frame)
    );

    assign done_evt = sh_done && (is_master ? m_busy_q : ss_active);
    assign flag_clr = armed_q && (wr_data || rd_data);

    // Control register; a mode fault overrides any master-bit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mstr_q <= 1'b0;
            ie_q   <= 1'b0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= reg_wdata[CTL_EN];
                mstr_q <= reg_wdata[CTL_MSTR];
                ie_q   <= reg_wdata[CTL_IE];
                div_q  <= reg_wdata[CTL_DIV_LO +: 2];
            end
            if (fault) mstr_q <= 1'b0;
        end
    end

    // Master transfer-in-progress state.
    always_ff @(posedge clk) begin
        if (!rst_n || !is_master || fault) m_busy_q <= 1'b0;
        else if (sh_load)                  m_busy_q <= 1'b1;
        else if (sh_done)                  m_busy_q <= 1'b0;
    end

    // Status flags and the read-status-then-access clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            col_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (done_evt || fault)          done_q <= 1'b1;
            else if (flag_clr)              done_q <= 1'b0;
            if (wr_data && busy_any)        col_q  <= 1'b1;
            else if (flag_clr)              col_q  <= 1'b0;
            if (rd_stat && (done_q || col_q)) armed_q <= 1'b1;
            else if (flag_clr)              armed_q <= 1'b0;
        end
    end

    // Receive holding buffer, overwritten by every completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_buf_q <= '0;
        else if (done_evt) rx_buf_q <= sh_rx;
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CTL_EN]            = en_q;
                reg_rdata[CTL_MSTR]          = mstr_q;
                reg_rdata[CTL_IE]            = ie_q;
                reg_rdata[CTL_DIV_LO +: 2]   = div_q;
            end
            SEL_STAT: begin
                reg_rdata[ST_DONE] = done_q;
                reg_rdata[ST_COL]  = col_q;
            end
            SEL_DATA: reg_rdata = rx_buf_q;
            default:  reg_rdata = '0;
        endcase
    end

    // Pin direction overrides by role.
    always_comb begin
        mosi_oe = usr_mosi_dir;
        miso_oe = usr_miso_dir;
        sck_oe  = usr_sck_dir;
        ss_oe   = usr_ss_dir;
        if (is_master) begin
            miso_oe = 1'b0;
        end else if (is_slave) begin
            mosi_oe = 1'b0;
            sck_oe  = 1'b0;
            ss_oe   = 1'b0;
            miso_oe = usr_miso_dir && !ss_s;
        end
    end

    assign mosi_o = sh_tx;
    assign miso_o = sh_tx;
    assign sck_o  = div_sck;
    assign irq_o  = done_q && ie_q && glob_irq_en;

endmodule

// File: rtl/spi_link_chk.sv
// Property checker for spi_link_ctrl, attached through bind.
// Observes control state, strobes and pin overrides; drives nothing.
module spi_link_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_o,
    input logic ie_q,
    input logic glob_irq_en,
    input logic en_q,
    input logic mstr_q,
    input logic sck_oe,
    input logic mosi_oe,
    input logic usr_ss_dir,
    input logic ss_s,
    input logic wr_ctrl,
    input logic wdata_mstr,
    input logic wr_data,
    input logic busy_any,
    input logic col_q,
    input logic done_q,
    input logic done_evt
);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie_q && glob_irq_en));

    // R8
    slave_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !mstr_q) |-> (!sck_oe && !mosi_oe));

    // R10
    fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mstr_q && !usr_ss_dir && !ss_s) |=> !mstr_q);

    // R12
    mstr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mstr_q) |-> $past(wr_ctrl && wdata_mstr));

    // R3
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy_any) |=> col_q);

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(done_evt || (en_q && mstr_q && !usr_ss_dir && !ss_s)));

endmodule

bind spi_link_ctrl spi_link_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .ie_q       (ie_q),
    .glob_irq_en(glob_irq_en),
    .en_q       (en_q),
    .mstr_q     (mstr_q),
    .sck_oe     (sck_oe),
    .mosi_oe    (mosi_oe),
    .usr_ss_dir (usr_ss_dir),
    .ss_s       (ss_s),
    .wr_ctrl    (wr_ctrl),
    .wdata_mstr (reg_wdata[1]),
    .wr_data    (wr_data),
    .busy_any   (busy_any),
    .col_q      (col_q),
    .done_q     (done_q),
    .done_evt   (done_evt)
);

// File: tb/spi_link_ctrl_bench.sv
// Two controllers joined in a ring: u_spi_link_ctrl is master, u_peer is slave.
module spi_link_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                          16'h817E, 16'h0180, 16'h5AC3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic glob = 1'b0;
    logic m_ss_in = 1'b1, s_ss_n = 1'b1;
    logic m_ss_dir = 1'b0;

    logic [1:0] m_sel = '0, s_sel = '0;
    logic m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
    logic [7:0] m_wdata = '0, s_wdata = '0;
    logic [7:0] m_rdata, s_rdata;
    logic m_irq, s_irq;
    logic m_mosi_o, m_mosi_oe, m_miso_o, m_miso_oe, m_sck_o, m_sck_oe, m_ss_oe;
    logic s_mosi_o, s_mosi_oe, s_miso_o, s_miso_oe, s_sck_o, s_sck_oe, s_ss_oe;
    logic mosi_net, miso_net, sck_net;

    int total = 0, bad = 0, hi_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mosi_net = m_mosi_oe ? m_mosi_o : 1'b0;
    assign sck_net  = m_sck_oe  ? m_sck_o  : 1'b0;
    assign miso_net = s_miso_oe ? s_miso_o : 1'b1;

    always @(negedge clk) if (m_sck_o) hi_cnt++;

    spi_link_ctrl u_spi_link_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(m_sel), .reg_wr(m_wr), .reg_rd(m_rd),
        .reg_wdata(m_wdata), .reg_rdata(m_rdata), .glob_irq_en(glob), .irq_o(m_irq),
        .usr_mosi_dir(1'b1), .usr_miso_dir(1'b1), .usr_sck_dir(1'b1), .usr_ss_dir(m_ss_dir),
        .mosi_i(1'b0), .mosi_o(m_mosi_o), .mosi_oe(m_mosi_oe),
        .miso_i(miso_net), .miso_o(m_miso_o), .miso_oe(m_miso_oe),
        .sck_i(1'b0), .sck_o(m_sck_o), .sck_oe(m_sck_oe),
        .ss_i(m_ss_in), .ss_oe(m_ss_oe)
    );

    spi_link_ctrl u_peer (
        .clk(clk), .rst_n(rst_n), .reg_sel(s_sel), .reg_wr(s_wr), .reg_rd(s_rd),
        .reg_wdata(s_wdata), .reg_rdata(s_rdata), .glob_irq_en(1'b0), .irq_o(s_irq),
        .usr_mosi_dir(1'b1), .usr_miso_dir(1'b1), .usr_sck_dir(1'b1), .usr_ss_dir(1'b1),
        .mosi_i(mosi_net), .mosi_o(s_mosi_o), .mosi_oe(s_mosi_oe),
        .miso_i(1'b0), .miso_o(s_miso_o), .miso_oe(s_miso_oe),
        .sck_i(sck_net), .sck_o(s_sck_o), .sck_oe(s_sck_oe),
        .ss_i(s_ss_n), .ss_oe(s_ss_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit p, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (p) begin s_sel = a; s_wdata = d; s_wr = 1; end
        else   begin m_sel = a; m_wdata = d; m_wr = 1; end
        @(negedge clk);
        s_wr = 0; m_wr = 0;
    endtask

    task automatic rd(input bit p, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        if (p) begin s_sel = a; s_rd = 1; end
        else   begin m_sel = a; m_rd = 1; end
        #1;
        d = p ? s_rdata : m_rdata;
        @(negedge clk);
        s_rd = 0; m_rd = 0;
    endtask

    task automatic clear_flags(input bit p);
        logic [7:0] d;
        rd(p, A_STAT, d);
        rd(p, A_DATA, d);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic resync_peer();
        @(negedge clk); s_ss_n = 1'b1;
        cycles(8);
        @(negedge clk); s_ss_n = 1'b0;
        cycles(8);
    endtask

    initial begin : main
        logic [7:0] d, prev;
        int start;
        cycles(5);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(0, A_CTRL, d); chk("R1 ctrl", d, 8'h00);
        rd(0, A_STAT, d); chk("R1 stat", d, 8'h00);
        rd(0, A_DATA, d); chk("R1 data", d, 8'h00);
        chk("R1 irq", m_irq, 1'b0);
        // R7 disabled: miso follows user direction
        chk("R7 disabled miso_oe", m_miso_oe, 1'b1);

        wr(0, A_CTRL, 8'h0B);
        wr(1, A_CTRL, 8'h01);
        cycles(4); @(negedge clk);
        chk("R7 master overrides", {m_miso_oe, m_mosi_oe, m_sck_oe, m_ss_oe}, 4'b0110);
        chk("R8 slave overrides ss high", {s_miso_oe, s_mosi_oe, s_sck_oe, s_ss_oe}, 4'b0000);
        s_ss_n = 1'b0;
        cycles(5); @(negedge clk);
        chk("R8 slave miso drives ss low", s_miso_oe, 1'b1);

        // R2/R5 vector table of ring exchanges
        for (int i = 0; i < NVEC; i++) begin
            wr(1, A_DATA, VEC[i][7:0]);
            wr(0, A_DATA, VEC[i][15:8]);
            chk("R2 first bit msb", m_mosi_o, VEC[i][15]);
            cycles(40);
            rd(0, A_STAT, d); chk("R5 flag clear mid transfer", d, 8'h00);
            cycles(110);
            rd(0, A_STAT, d); chk("R5 flag set after eighth bit", d, 8'h01);
            rd(0, A_DATA, d); chk("R2 master rx", d, {24'd0, VEC[i][7:0]});
            rd(0, A_STAT, d); chk("R5 flag cleared", d, 8'h00);
            rd(1, A_STAT, d); chk("R5 slave flag", d, 8'h01);
            rd(1, A_DATA, d); chk("R2 slave rx", d, {24'd0, VEC[i][15:8]});
        end

        // R3 collision: second write refused
        wr(1, A_DATA, 8'h42);
        wr(0, A_DATA, 8'h11);
        cycles(30);
        wr(0, A_DATA, 8'h99);
        rd(0, A_STAT, d); chk("R3 collision flag", d, 8'h02);
        cycles(120);
        rd(0, A_STAT, d); chk("R3 both flags", d, 8'h03);
        rd(0, A_DATA, d); chk("R3 master rx", d, 8'h42);
        rd(0, A_STAT, d); chk("R5 both flags cleared", d, 8'h00);
        rd(1, A_DATA, d); chk("R3 shifted byte unchanged", d, 8'h11);
        clear_flags(1);

        // R4 double buffer and overwrite
        wr(1, A_DATA, 8'hC1);
        wr(0, A_DATA, 8'h10);
        cycles(150);
        wr(0, A_DATA, 8'h20);
        cycles(40);
        rd(0, A_DATA, d); chk("R4 first byte readable", d, 8'hC1);
        cycles(120);
        rd(0, A_DATA, d); chk("R4 overwritten by second", d, 8'h10);
        rd(1, A_DATA, d); chk("R4 slave overwritten", d, 8'h20);
        clear_flags(0); clear_flags(1);

        // R11 interrupt gating
        wr(0, A_CTRL, 8'h0F);
        wr(0, A_DATA, 8'h66);
        cycles(150); @(negedge clk);
        chk("R11 irq masked by global", m_irq, 1'b0);
        glob = 1'b1; #1;
        chk("R11 irq raised", m_irq, 1'b1);
        wr(0, A_CTRL, 8'h0B); #1;
        chk("R11 irq masked by enable", m_irq, 1'b0);
        glob = 1'b0;
        clear_flags(0); clear_flags(1);

        // R6 divider ratios
        wr(0, A_CTRL, 8'h03);
        start = hi_cnt; wr(0, A_DATA, 8'h55); cycles(60);
        chk("R6 div4 high time", hi_cnt - start, 16);
        wr(0, A_CTRL, 8'h13);
        start = hi_cnt; wr(0, A_DATA, 8'h55); cycles(560);
        chk("R6 div64 high time", hi_cnt - start, 256);
        wr(0, A_CTRL, 8'h1B);
        start = hi_cnt; wr(0, A_DATA, 8'h55); cycles(1100);
        chk("R6 div128 high time", hi_cnt - start, 512);
        wr(0, A_CTRL, 8'h0B);
        start = hi_cnt; wr(0, A_DATA, 8'h55); cycles(150);
        chk("R6 div16 high time", hi_cnt - start, 64);
        clear_flags(0); clear_flags(1);
        resync_peer();

        // R9 select as output has no effect
        m_ss_dir = 1'b1; m_ss_in = 1'b0;
        cycles(10);
        rd(0, A_CTRL, d); chk("R9 master kept", d, 8'h0B);
        rd(0, A_STAT, d); chk("R9 no flag", d, 8'h00);
        chk("R9 ss output", m_ss_oe, 1'b1);
        m_ss_in = 1'b1; m_ss_dir = 1'b0;
        cycles(5);

        // R10 mode fault mid transfer
        wr(0, A_DATA, 8'h77);
        cycles(30);
        @(negedge clk); m_ss_in = 1'b0;
        cycles(8);
        rd(0, A_CTRL, d); chk("R10 master bit cleared", d, 8'h09);
        rd(0, A_STAT, d); chk("R10 flag set", d, 8'h01);
        chk("R10 pins released", {m_sck_oe, m_mosi_oe}, 2'b00);
        m_ss_in = 1'b1;
        cycles(8);
        rd(0, A_CTRL, d); chk("R12 stays slave", d, 8'h09);
        wr(0, A_CTRL, 8'h0B);
        rd(0, A_CTRL, d); chk("R12 master restored", d, 8'h0B);
        clear_flags(0);
        resync_peer();
        clear_flags(1);

        // R13 deselected slave ignores clock
        @(negedge clk); s_ss_n = 1'b1;
        cycles(6); @(negedge clk);
        chk("R13 slave miso off", s_miso_oe, 1'b0);
        rd(1, A_DATA, prev);
        wr(0, A_DATA, 8'hE7);
        cycles(150);
        rd(1, A_STAT, d); chk("R13 slave flag", d, 8'h00);
        rd(1, A_DATA, d); chk("R13 slave data", d, prev);
        rd(0, A_DATA, d); chk("R13 master sees idle line", d, 8'hFF);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        cycles(150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule